// File: doc/BRIEF.md
# Relocatable Sector Decoder with Write Protection

This block sits between a processor's external memory bus and two flash arrays that work independently of each other: a main array of eight 64 KB sectors and a secondary array of eight 8 KB sectors. It turns each bus cycle into at most one registered select line. That line points to one main sector, one secondary sector, or the on-chip control-register group. Each sector has a base address that software can program, so a sector can be placed anywhere in the 16 MB space. Each sector also has its own write-protect bit. A write that lands on a protected sector is dropped, and a one-cycle violation pulse is raised instead.

Four more programmable address windows (base, mask and enable) drive external chip-select outputs. These windows are separate from the internal decode.

The bus-facing decision is made by a small access state machine. It has four named states:
- ST_IDLE: no access.
- ST_READ: a granted read.
- ST_WRITE: a granted write.
- ST_BLOCK: a write refused by protection.

On every clock the next state is chosen from the current inputs:
- Chip enable off, no strobe, both strobes, or no target leads to ST_IDLE.
- A read with a target leads to ST_READ.
- A write to an unprotected target leads to ST_WRITE.
- A write to a protected target leads to ST_BLOCK.

Any state may go to any state. The violation pulse is raised only on a transition into ST_BLOCK from a different state.

Top module: `sector_decode_top`

## Requirements
- R1: After reset:
  - All outputs are low and all write-protect bits are clear.
  - Main sector i sits at i*0x10000.
  - Secondary sector i sits at 0x80000 + i*0x2000.
  - The register group sits at 0x90000.
  - The external windows are disabled.
- R2: A read with bus_ce high and bus_rd high, bus_wr low, raises main_sel[i] and mem_rd one cycle later when address bits [23:16] equal the base of main sector i. The low 16 bits of both the address and the base are ignored.
- R3: Secondary sector i matches on address bits [23:13] against its base and drives sec_sel[i] one cycle later.
- R4: The register group matches on address bits [23:8] (a 256-byte window) and drives reg_sel one cycle later.
- R5: When several windows match, the lowest-numbered main sector wins, then the lowest-numbered secondary sector, then the register group. At most one select is high.
- R6: A configuration write (cfg_we high) stores cfg_wdata at cfg_addr and takes effect for bus cycles from the next clock. The map is:
  - Offsets 0-7: main bases.
  - Offsets 8-15: secondary bases.
  - Offset 16: register-group base.
  - Offset 17: main protect mask, bit i for sector i.
  - Offset 18: secondary protect mask.
  - Offsets 20-23: window bases.
  - Offsets 24-27: window masks.
  - Offset 28: window enables, bit j for window j.
- R7: A write whose winning target is a protected sector asserts no select and no mem_wr. Reads of protected sectors are granted, and register-group writes are never blocked.
- R8: wp_viol is high for exactly one cycle, one cycle after the first clock of a blocked write. A blocked write held on further clocks gives no further pulse.
- R9: With bus_ce low, every select, mem_rd, mem_wr, ext_cs and wp_viol are low on the next cycle.
- R10: bus_rd and bus_wr both high is treated as no access.
- R11: ext_cs[j] is high one cycle after a single-strobe access with bus_ce high when window j is enabled and (address XOR base) AND mask is zero. This holds whatever the internal decode and protection result.
- R12: The protect masks of the two arrays are independent. Reads of one array and writes of the other may alternate on consecutive clocks with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration register offset |
| cfg_wdata | input | 24 | Configuration write data |
| bus_addr | input | 24 | Processor byte address |
| bus_ce | input | 1 | Chip enable, active high |
| bus_rd | input | 1 | Read strobe, active high |
| bus_wr | input | 1 | Write strobe, active high |
| main_sel | output | 8 | Main-array sector selects |
| sec_sel | output | 8 | Secondary-array sector selects |
| reg_sel | output | 1 | Control-register group select |
| mem_rd | output | 1 | Granted read |
| mem_wr | output | 1 | Granted (unprotected) write |
| ext_cs | output | 4 | External chip selects |
| wp_viol | output | 1 | One-cycle protection-violation pulse |

## Verification
The assertions check these properties on every cycle:
- At most one select is high.
- A select is never present without exactly one granted strobe.
- A violation pulse never lasts two cycles and never comes with a granted write.
- Chip-enable low and double strobes leave the outputs idle.

Only the bench scenarios can show the following:
- The right sector is chosen after relocation.
- The priority order holds between overlapping windows.
- A protect bit hits only its own sector and array.
- Held blocked writes stay silent.
- The external windows follow their mask and enable.

// File: rtl/sdec_pkg.sv
`timescale 1ns/1ps
package sdec_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_BLOCK = 2'd3
    } acc_state_e;
endpackage

// File: rtl/sdec_cfg_regs.sv
`timescale 1ns/1ps
module sdec_cfg_regs #(
    parameter int ADDR_W   = 24,
    parameter int N_MAIN   = 8,
    parameter int N_SEC    = 8,
    parameter int N_XCS    = 4,
    parameter int MAIN_OFF = 16,
    parameter int SEC_OFF  = 13,
    parameter int REG_OFF  = 8,
    parameter int CFG_AW   = 5,
    localparam int MAIN_TW = ADDR_W - MAIN_OFF,
    localparam int SEC_TW  = ADDR_W - SEC_OFF,
    localparam int REG_TW  = ADDR_W - REG_OFF
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_we,
    input  logic [CFG_AW-1:0]              cfg_addr,
    input  logic [ADDR_W-1:0]              cfg_wdata,
    output logic [N_MAIN-1:0][MAIN_TW-1:0] main_tag,
    output logic [N_SEC-1:0][SEC_TW-1:0]   sec_tag,
    output logic [REG_TW-1:0]              reg_tag,
    output logic [N_MAIN-1:0]              main_wp,
    output logic [N_SEC-1:0]               sec_wp,
    output logic [N_XCS-1:0][ADDR_W-1:0]   xcs_base,
    output logic [N_XCS-1:0][ADDR_W-1:0]   xcs_mask,
    output logic [N_XCS-1:0]               xcs_en
);
    // register offsets
    localparam int A_SEC0  = N_MAIN;
    localparam int A_REG   = N_MAIN + N_SEC;
    localparam int A_MWP   = A_REG + 1;
    localparam int A_SWP   = A_REG + 2;
    localparam int A_XBASE = A_REG + 4;
    localparam int A_XMASK = A_XBASE + N_XCS;
    localparam int A_XEN   = A_XMASK + N_XCS;
    // default layout: main array from zero, secondary right above, registers after
    localparam int SEC_ORG = N_MAIN << MAIN_OFF;
    localparam int REG_ORG = SEC_ORG + (N_SEC << SEC_OFF);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_MAIN; i++) main_tag[i] <= MAIN_TW'(i);
            for (int i = 0; i < N_SEC; i++)  sec_tag[i]  <= SEC_TW'((SEC_ORG >> SEC_OFF) + i);
            reg_tag  <= REG_TW'(REG_ORG >> REG_OFF);
            main_wp  <= '0;
            sec_wp   <= '0;
            xcs_base <= '0;
            xcs_mask <= '0;
            xcs_en   <= '0;
        end else if (cfg_we) begin
            for (int i = 0; i < N_MAIN; i++)
                if (int'(cfg_addr) == i) main_tag[i] <= cfg_wdata[ADDR_W-1:MAIN_OFF];
            for (int i = 0; i < N_SEC; i++)
                if (int'(cfg_addr) == A_SEC0 + i) sec_tag[i] <= cfg_wdata[ADDR_W-1:SEC_OFF];
            if (int'(cfg_addr) == A_REG) reg_tag <= cfg_wdata[ADDR_W-1:REG_OFF];
            if (int'(cfg_addr) == A_MWP) main_wp <= cfg_wdata[N_MAIN-1:0];
            if (int'(cfg_addr) == A_SWP) sec_wp  <= cfg_wdata[N_SEC-1:0];
            for (int j = 0; j < N_XCS; j++) begin
                if (int'(cfg_addr) == A_XBASE + j) xcs_base[j] <= cfg_wdata;
                if (int'(cfg_addr) == A_XMASK + j) xcs_mask[j] <= cfg_wdata;
            end
            if (int'(cfg_addr) == A_XEN) xcs_en <= cfg_wdata[N_XCS-1:0];
        end
    end
endmodule

// File: rtl/sdec_window_match.sv
`timescale 1ns/1ps
module sdec_window_match #(
    parameter int ADDR_W   = 24,
    parameter int N        = 8,
    parameter int OFF_BITS = 16,
    localparam int TAG_W   = ADDR_W - OFF_BITS
) (
    input  logic [TAG_W-1:0]          addr_tag,
    input  logic [N-1:0][TAG_W-1:0]   base_tag,
    output logic [N-1:0]              hit
);
    for (genvar i = 0; i < N; i++) begin : g_win
        assign hit[i] = (addr_tag == base_tag[i]);
    end
endmodule

// File: rtl/sdec_xcs.sv
`timescale 1ns/1ps
module sdec_xcs #(
    parameter int ADDR_W = 24,
    parameter int N_XCS  = 4
) (
    input  logic [ADDR_W-1:0]            addr,
    input  logic [N_XCS-1:0][ADDR_W-1:0] base,
    input  logic [N_XCS-1:0][ADDR_W-1:0] mask,
    input  logic [N_XCS-1:0]             en,
    output logic [N_XCS-1:0]             hit
);
    for (genvar j = 0; j < N_XCS; j++) begin : g_xw
        assign hit[j] = en[j] && (((addr ^ base[j]) & mask[j]) == '0);
    end
endmodule

// File: rtl/sdec_access_fsm.sv
`timescale 1ns/1ps
module sdec_access_fsm
    import sdec_pkg::*;
#(
    parameter int N_MAIN = 8,
    parameter int N_SEC  = 8,
    parameter int N_XCS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_ce,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [N_MAIN-1:0] main_hit,
    input  logic [N_SEC-1:0]  sec_hit,
    input  logic              reg_hit,
    input  logic [N_MAIN-1:0] main_wp,
    input  logic [N_SEC-1:0]  sec_wp,
    input  logic [N_XCS-1:0]  xcs_hit,
    output logic [N_MAIN-1:0] main_sel,
    output logic [N_SEC-1:0]  sec_sel,
    output logic              reg_sel,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [N_XCS-1:0]  ext_cs,
    output logic              wp_viol
);
    acc_state_e state, nxt;
    logic [N_MAIN-1:0] main_pick;
    logic [N_SEC-1:0]  sec_pick;
    logic              reg_pick, any_pick, prot, rd_only, wr_only;

    // fixed priority: lowest main, then lowest secondary, then registers
    always_comb begin
        main_pick = main_hit & (~main_hit + N_MAIN'(1));
        sec_pick  = (|main_hit) ? '0 : (sec_hit & (~sec_hit + N_SEC'(1)));
        reg_pick  = !(|main_hit) && !(|sec_hit) && reg_hit;
        any_pick  = (|main_pick) || (|sec_pick) || reg_pick;
        prot      = (|(main_pick & main_wp)) || (|(sec_pick & sec_wp));
        rd_only   = bus_ce && bus_rd && !bus_wr;
        wr_only   = bus_ce && bus_wr && !bus_rd;
    end

    always_comb begin
        if (rd_only && any_pick)       nxt = ST_READ;
        else if (wr_only && any_pick)  nxt = prot ? ST_BLOCK : ST_WRITE;
        else                           nxt = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            main_sel <= '0; sec_sel <= '0; reg_sel <= 1'b0;
            mem_rd <= 1'b0; mem_wr <= 1'b0; ext_cs <= '0; wp_viol <= 1'b0;
        end else begin
            main_sel <= '0; sec_sel <= '0; reg_sel <= 1'b0;
            mem_rd <= 1'b0; mem_wr <= 1'b0; wp_viol <= 1'b0;
            ext_cs <= (rd_only || wr_only) ? xcs_hit : '0;
            unique case (nxt)
                ST_IDLE: ;
                ST_READ: begin
                    main_sel <= main_pick; sec_sel <= sec_pick; reg_sel <= reg_pick;
                    mem_rd   <= 1'b1;
                end
                ST_WRITE: begin
                    main_sel <= main_pick; sec_sel <= sec_pick; reg_sel <= reg_pick;
                    mem_wr   <= 1'b1;
                end
                ST_BLOCK: wp_viol <= (state != ST_BLOCK);
            endcase
        end
    end

    // R5: never more than one target
    a_r5_single_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({main_sel, sec_sel, reg_sel}));
    // R8: violation is a single-cycle pulse
    a_r8_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        wp_viol |=> !wp_viol);
    // R7: a refused write leaves every select and the write strobe low
    a_r7_blocked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        wp_viol |-> (!mem_wr && !mem_rd && main_sel == '0 && sec_sel == '0 && !reg_sel));
    // R2: a select always comes with exactly one granted strobe
    a_r2_sel_has_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (|{main_sel, sec_sel, reg_sel}) |-> (mem_rd ^ mem_wr));
    a_r2_strobe_has_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> (|{main_sel, sec_sel, reg_sel}));
endmodule

// File: rtl/sector_decode_top.sv
`timescale 1ns/1ps
module sector_decode_top #(
    parameter int ADDR_W   = 24,
    parameter int N_MAIN   = 8,
    parameter int N_SEC    = 8,
    parameter int N_XCS    = 4,
    parameter int MAIN_OFF = 16,
    parameter int SEC_OFF  = 13,
    parameter int REG_OFF  = 8,
    parameter int CFG_AW   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_ce,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic [N_MAIN-1:0] main_sel,
    output logic [N_SEC-1:0]  sec_sel,
    output logic              reg_sel,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [N_XCS-1:0]  ext_cs,
    output logic              wp_viol
);
    localparam int MAIN_TW = ADDR_W - MAIN_OFF;
    localparam int SEC_TW  = ADDR_W - SEC_OFF;
    localparam int REG_TW  = ADDR_W - REG_OFF;

    logic [N_MAIN-1:0][MAIN_TW-1:0] main_tag;
    logic [N_SEC-1:0][SEC_TW-1:0]   sec_tag;
    logic [0:0][REG_TW-1:0]         reg_tag;
    logic [N_MAIN-1:0]              main_wp, main_hit;
    logic [N_SEC-1:0]               sec_wp, sec_hit;
    logic [0:0]                     reg_hit;
    logic [N_XCS-1:0][ADDR_W-1:0]   xcs_base, xcs_mask;
    logic [N_XCS-1:0]               xcs_en, xcs_hit;

    sdec_cfg_regs #(
        .ADDR_W(ADDR_W), .N_MAIN(N_MAIN), .N_SEC(N_SEC), .N_XCS(N_XCS),
        .MAIN_OFF(MAIN_OFF), .SEC_OFF(SEC_OFF), .REG_OFF(REG_OFF), .CFG_AW(CFG_AW)
    ) i_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .main_tag(main_tag), .sec_tag(sec_tag),
        .reg_tag(reg_tag[0]), .main_wp(main_wp), .sec_wp(sec_wp),
        .xcs_base(xcs_base), .xcs_mask(xcs_mask), .xcs_en(xcs_en)
    );

    sdec_window_match #(.ADDR_W(ADDR_W), .N(N_MAIN), .OFF_BITS(MAIN_OFF)) i_main_match (
        .addr_tag(bus_addr[ADDR_W-1:MAIN_OFF]), .base_tag(main_tag), .hit(main_hit));
    sdec_window_match #(.ADDR_W(ADDR_W), .N(N_SEC), .OFF_BITS(SEC_OFF)) i_sec_match (
        .addr_tag(bus_addr[ADDR_W-1:SEC_OFF]), .base_tag(sec_tag), .hit(sec_hit));
    sdec_window_match #(.ADDR_W(ADDR_W), .N(1), .OFF_BITS(REG_OFF)) i_reg_match (
        .addr_tag(bus_addr[ADDR_W-1:REG_OFF]), .base_tag(reg_tag), .hit(reg_hit));

    sdec_xcs #(.ADDR_W(ADDR_W), .N_XCS(N_XCS)) i_xcs (
        .addr(bus_addr), .base(xcs_base), .mask(xcs_mask), .en(xcs_en), .hit(xcs_hit));

    sdec_access_fsm #(.N_MAIN(N_MAIN), .N_SEC(N_SEC), .N_XCS(N_XCS)) i_fsm (
        .clk(clk), .rst_n(rst_n), .bus_ce(bus_ce), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .main_hit(main_hit), .sec_hit(sec_hit), .reg_hit(reg_hit[0]),
        .main_wp(main_wp), .sec_wp(sec_wp), .xcs_hit(xcs_hit),
        .main_sel(main_sel), .sec_sel(sec_sel), .reg_sel(reg_sel),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .ext_cs(ext_cs), .wp_viol(wp_viol)
    );

    // R9: chip enable low gives an idle output cycle
    a_r9_ce_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ce |=> (main_sel == '0 && sec_sel == '0 && !reg_sel && !mem_rd
                     && !mem_wr && ext_cs == '0 && !wp_viol));
    // R10: both strobes at once is no access
    a_r10_both_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_wr) |=> (!mem_rd && !mem_wr && !wp_viol && ext_cs == '0));
endmodule

// File: tb/test_sector_decode_top.sv
`timescale 1ns/1ps
module test_sector_decode_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [23:0] cfg_wdata = '0;
    logic [23:0] bus_addr = '0;
    logic        bus_ce = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0]  main_sel, sec_sel;
    logic        reg_sel, mem_rd, mem_wr, wp_viol;
    logic [3:0]  ext_cs;

    int checks = 0, errors = 0;
    logic [23:0] exp_q[$];
    string       tag_q[$];

    // reference configuration kept by the bench
    logic [23:0] m_main[8], m_sec[8], m_xb[4], m_xm[4];
    logic [23:0] m_reg;
    logic [7:0]  m_mwp, m_swp;
    logic [3:0]  m_xen;
    logic        prev_block;

    always #4 clk = ~clk;

    sector_decode_top i_sector_decode_top (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .bus_addr(bus_addr), .bus_ce(bus_ce),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .main_sel(main_sel), .sec_sel(sec_sel),
        .reg_sel(reg_sel), .mem_rd(mem_rd), .mem_wr(mem_wr), .ext_cs(ext_cs),
        .wp_viol(wp_viol));

    function automatic logic [23:0] actual();
        return {main_sel, sec_sel, reg_sel, mem_rd, mem_wr, ext_cs, wp_viol};
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 8; i++) begin
            m_main[i] = 24'(i * 24'h10000);
            m_sec[i]  = 24'(24'h80000 + i * 24'h2000);
        end
        for (int j = 0; j < 4; j++) begin m_xb[j] = '0; m_xm[j] = '0; end
        m_reg = 24'h90000; m_mwp = '0; m_swp = '0; m_xen = '0; prev_block = 1'b0;
    endtask

    task automatic cfg(input int a, input logic [23:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = d; bus_ce = 1'b0;
        bus_rd = 1'b0; bus_wr = 1'b0;
        if (a < 8) m_main[a] = d;
        else if (a < 16) m_sec[a-8] = d;
        else if (a == 16) m_reg = d;
        else if (a == 17) m_mwp = d[7:0];
        else if (a == 18) m_swp = d[7:0];
        else if (a >= 20 && a < 24) m_xb[a-20] = d;
        else if (a >= 24 && a < 28) m_xm[a-24] = d;
        else if (a == 28) m_xen = d[3:0];
        prev_block = 1'b0;
    endtask

    // driver: apply one bus cycle and queue the expected registered result
    task automatic access(input logic [23:0] a, input logic ce, input logic rd,
                          input logic wr, input string tag);
        logic [7:0] ms, ss; logic rs, ro, wo, v, blk, found; logic [3:0] xc;
        @(negedge clk);
        cfg_we = 1'b0; bus_addr = a; bus_ce = ce; bus_rd = rd; bus_wr = wr;
        ms = '0; ss = '0; rs = 1'b0; ro = 1'b0; wo = 1'b0; v = 1'b0; xc = '0; blk = 1'b0;
        if (ce && (rd ^ wr)) begin
            found = 1'b0;
            for (int j = 0; j < 4; j++)
                if (m_xen[j] && (((a ^ m_xb[j]) & m_xm[j]) == 24'h0)) xc[j] = 1'b1;
            for (int i = 0; i < 8; i++)
                if (!found && a[23:16] == m_main[i][23:16]) begin ms[i] = 1'b1; found = 1'b1; end
            for (int i = 0; i < 8; i++)
                if (!found && a[23:13] == m_sec[i][23:13]) begin ss[i] = 1'b1; found = 1'b1; end
            if (!found && a[23:8] == m_reg[23:8]) begin rs = 1'b1; found = 1'b1; end
            if (found) begin
                if (rd) ro = 1'b1;
                else if ((|(ms & m_mwp)) || (|(ss & m_swp))) begin
                    blk = 1'b1; v = !prev_block; ms = '0; ss = '0;
                end else wo = 1'b1;
            end
        end
        prev_block = blk;
        exp_q.push_back({ms, ss, rs, ro, wo, xc, v});
        tag_q.push_back(tag);
    endtask

    // monitor: compare each queued expectation just after the following edge
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            logic [23:0] e; string t;
            e = exp_q.pop_front(); t = tag_q.pop_front();
            checks++;
            if (actual() !== e) begin
                errors++;
                $display("FAIL %s: actual %h expected %h", t, actual(), e);
            end
        end
    end

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        checks++;
        if (actual() !== 24'h0) begin
            errors++; $display("FAIL R1: actual %h expected %h", actual(), 24'h0);
        end
        // R1/R2/R3/R4 default layout
        access(24'h03ABCD, 1, 1, 0, "R2 main3 default");
        access(24'h08A123, 1, 1, 0, "R3 sec5 default");
        access(24'h090010, 1, 1, 0, "R4 reg window");
        access(24'h090110, 1, 1, 0, "R4 outside reg window");
        access(24'h0A0000, 1, 1, 0, "R1 unmapped");
        // R6 relocation; low base bits ignored
        cfg(2, 24'h5A1234);
        access(24'h5AFFFF, 1, 1, 0, "R6 main2 moved");
        access(24'h020000, 1, 1, 0, "R6 old main2 window empty");
        // R5 priority between overlapping windows
        cfg(8, 24'h5A0000);
        cfg(9, 24'h5A0000);
        cfg(16, 24'h5A0000);
        access(24'h5A0040, 1, 1, 0, "R5 main over sec and reg");
        cfg(2, 24'hF00000);
        access(24'h5A0040, 1, 1, 0, "R5 lowest sec wins");
        cfg(8, 24'hE00000);
        access(24'h5A0040, 1, 1, 0, "R5 sec1 over reg");
        cfg(9, 24'hE20000);
        access(24'h5A0040, 1, 1, 0, "R5 reg last");
        access(24'h5A0040, 1, 0, 1, "R7 reg write never blocked");
        // R7/R8 protection
        cfg(17, 24'h000008);
        access(24'h030000, 1, 0, 1, "R8 first blocked write");
        access(24'h030000, 1, 0, 1, "R8 held blocked write");
        access(24'h03FFFE, 1, 0, 1, "R8 held blocked write 2");
        access(24'h030000, 1, 1, 0, "R7 read of protected");
        access(24'h040000, 1, 0, 1, "R7 unprotected write");
        access(24'h030000, 1, 0, 1, "R8 new blocked write");
        // R12 independence of arrays
        cfg(18, 24'h000020);
        access(24'h086000, 1, 0, 1, "R12 sec3 write with main wp3");
        access(24'h08A000, 1, 0, 1, "R12 sec5 protected");
        access(24'h040000, 1, 0, 1, "R12 main write");
        access(24'h08A000, 1, 1, 0, "R12 sec read");
        access(24'h040010, 1, 0, 1, "R12 main write again");
        access(24'h08A010, 1, 1, 0, "R12 sec read again");
        // R9 chip enable, R10 both strobes
        access(24'h040000, 0, 1, 0, "R9 ce low read");
        access(24'h030000, 0, 0, 1, "R9 ce low protected write");
        access(24'h040000, 1, 1, 1, "R10 both strobes");
        access(24'h040000, 1, 0, 0, "R10 no strobe");
        // R11 external windows
        cfg(20, 24'hC00000); cfg(24, 24'hF00000);
        cfg(21, 24'h030000); cfg(25, 24'hFF0000);
        cfg(22, 24'h040000); cfg(26, 24'hFF0000);
        cfg(28, 24'h000003);
        access(24'hC12345, 1, 1, 0, "R11 window0 no target");
        access(24'h030000, 1, 0, 1, "R11 window1 with blocked write");
        access(24'h040000, 1, 1, 0, "R11 disabled window2");
        access(24'hC12345, 0, 1, 0, "R11 R9 window with ce low");
        access(24'hD00000, 1, 0, 1, "R11 outside window0");
        @(negedge clk);
        bus_ce = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0;
        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule